// File: doc/BRIEF.md
# Gap-Modulated Low-Frequency Downlink Encoder

This block sends one reader-to-tag command to a writable low-frequency tag. It sends the command by switching the reader's carrier field on and off. A single start pulse captures a 32-bit data word, a 3-bit block address, a 32-bit password and a 7-bit control word. The block then builds the command frame and plays it out on `field_on`. The control word picks the page, test mode, password use, read or write, and whether the address is sent. It also picks one of four downlink codings.

The timing is counted in `tick` periods, where a tick is normally 1 µs. Every duration is a whole number of timing units. One unit is `TICKS_PER_UNIT` ticks, and the default of 8 gives 8 µs. The field is off between symbols and on during each symbol pulse. After the last gap the field goes back on and stays on, so the tag can answer. A one-cycle `done` pulse then marks the end of the command.

Control word fields, by bit position: bit 0 adds the password, bit 1 is the page, bit 2 is test mode, bits 4:3 choose the coding (0 fixed, 1 long reference, 2 leading zero, 3 one-of-four), bit 5 leaves out the address, and bit 6 marks a read, which leaves out the data.

Top module: `lf_gap_downlink`

## Requirements
- R1: After reset, `field_on` is 1 and `done` is 0.
- R2: On `start`, the field goes off for 31 units (248 µs). Each symbol that follows is an on-pulse, then an off-gap of exactly 20 units (160 µs).
- R3: The frame is sent MSB first, in this order: any coding prefix, a 2-bit opcode, the optional 32-bit password, a lock bit of 0, the optional 32-bit data word, and the optional 3-bit address.
- R4: The opcode is 1 then the page bit (ctrl bit 1). When test mode is set (ctrl bit 2), the opcode is 0 then 1.
- R5: A read (ctrl bit 6) leaves out the data word. Regular-read (ctrl bit 5) leaves out the address.
- R6: In fixed coding (mode 0), each bit is one pulse: 18 units (144 µs) for a 0 and 50 units (400 µs) for a 1.
- R7: In long-reference coding (mode 1), a reference pulse of 154 units (1232 µs) and its gap come before the frame. The frame bits then use the R6 timing.
- R8: In leading-zero coding (mode 2), the frame starts with one 0 bit, and a password is preceded by two 0 bits. A 1 lasts 40 units (320 µs) and a 0 lasts 18 units.
- R9: In one-of-four coding (mode 3), the frame starts with two 0 bits, and a password is preceded by two 0 bits. Bits go out in pairs, first bit as the MSB. The pair values 0, 1, 2 and 3 last 18, 34, 50 and 66 units. A frame of odd length is padded with a trailing 0.
- R10: When the last gap ends, `field_on` goes high and stays high. `done` pulses for one cycle one tick later.
- R11: A `start`, or a change on the command inputs, while a command is in progress has no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base strobe, normally once per µs |
| start | input | 1 | Captures the command and begins the frame |
| cmd_data | input | DATA_W | Data word to write |
| cmd_addr | input | ADDR_W | Block address |
| cmd_pwd | input | DATA_W | Password |
| cmd_ctrl | input | 7 | Control word (fields listed above) |
| field_on | output | 1 | Carrier enable; 1 means field on |
| done | output | 1 | One-cycle pulse when the command has been sent |

## Verification
The bench builds the block with `TICKS_PER_UNIT` set to 1 and holds `tick` high, so one timing unit is one clock cycle. This cuts each frame to an eighth of its normal length. It leaves room for a near-exhaustive sweep: each of the four codings, crossed with password write, plain write on the other page, addressed read, regular read and test-mode write, including the odd-length pair padding. Each pulse width the bench measures maps straight onto the unit counts in R2 and R6 to R9.

// File: rtl/lf_dl_pkg.sv
package lf_dl_pkg;

  typedef enum logic [1:0] {
    DL_FIXED   = 2'd0,
    DL_LONGREF = 2'd1,
    DL_LEADZ   = 2'd2,
    DL_QUAD    = 2'd3
  } dl_mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SGAP, S_REF, S_PULSE, S_GAP, S_FIN
  } seq_state_e;

  // durations in timing units
  localparam int unsigned U_START     = 31;
  localparam int unsigned U_GAP       = 20;
  localparam int unsigned U_ZERO      = 18;
  localparam int unsigned U_ONE       = 50;
  localparam int unsigned U_ONE_LZ    = 40;
  localparam int unsigned U_STEP_Q    = 16;
  localparam int unsigned U_REF_EXTRA = 136;
  localparam int unsigned U_MAX       = U_ZERO + U_REF_EXTRA;

  function automatic int unsigned sym_units(dl_mode_e m, logic [1:0] s);
    case (m)
      DL_QUAD:  return U_ZERO + U_STEP_Q * int'(s);
      DL_LEADZ: return s[0] ? U_ONE_LZ : U_ZERO;
      default:  return s[0] ? U_ONE : U_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/lf_dl_framer.sv
module lf_dl_framer
  import lf_dl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int FRAME_W = 74,
  parameter int LEN_W   = 7
) (
  input  logic [DATA_W-1:0]  data,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  pwd,
  input  logic [6:0]         ctrl,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   len
);
  dl_mode_e md;
  logic lead, use_pwd, page, test, skip_addr, is_read;
  logic [FRAME_W-1:0] acc;
  logic [LEN_W-1:0]   n;

  assign use_pwd   = ctrl[0];
  assign page      = ctrl[1];
  assign test      = ctrl[2];
  assign md        = dl_mode_e'(ctrl[4:3]);
  assign skip_addr = ctrl[5];
  assign is_read   = ctrl[6];
  assign lead      = (md == DL_LEADZ) || (md == DL_QUAD);

  // right-aligned accumulation, then left-justify so the first bit is the MSB
  always_comb begin
    acc = '0;
    n   = '0;
    if (lead) begin
      acc = {acc[FRAME_W-2:0], 1'b0};
      n   = n + 1'b1;
    end
    if (md == DL_QUAD) begin
      acc = {acc[FRAME_W-2:0], 1'b0};
      n   = n + 1'b1;
    end
    acc = {acc[FRAME_W-3:0], (test ? 2'b01 : {1'b1, page})};
    n   = n + LEN_W'(2);
    if (use_pwd) begin
      if (lead) begin
        acc = {acc[FRAME_W-3:0], 2'b00};
        n   = n + LEN_W'(2);
      end
      acc = (acc << DATA_W) | FRAME_W'(pwd);
      n   = n + LEN_W'(DATA_W);
    end
    acc = {acc[FRAME_W-2:0], 1'b0};
    n   = n + 1'b1;
    if (!is_read) begin
      acc = (acc << DATA_W) | FRAME_W'(data);
      n   = n + LEN_W'(DATA_W);
    end
    if (!skip_addr) begin
      acc = (acc << ADDR_W) | FRAME_W'(addr);
      n   = n + LEN_W'(ADDR_W);
    end
    frame = acc << (LEN_W'(FRAME_W) - n);
    len   = n;
  end

endmodule

// File: rtl/lf_dl_timer.sv
module lf_dl_timer #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expire = tick && (cnt == CW'(1));

  // R2
  tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt));
  // R2
  tmr_load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));

endmodule

// File: rtl/lf_dl_seq.sv
module lf_dl_seq
  import lf_dl_pkg::*;
#(
  parameter int          FRAME_W        = 74,
  parameter int          LEN_W          = 7,
  parameter int          CW             = 11,
  parameter int unsigned TICKS_PER_UNIT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [LEN_W-1:0]   len_in,
  input  dl_mode_e           mode_in,
  input  logic               tmr_expire,
  output logic               tmr_load,
  output logic [CW-1:0]      tmr_val,
  output logic               field_on,
  output logic               done
);
  seq_state_e         state_q;
  dl_mode_e           mode_q;
  logic [FRAME_W-1:0] shreg;
  logic [LEN_W-1:0]   sym_left;
  logic               ref_pend, field_q, done_q;
  logic [1:0]         cur_sym;
  logic [LEN_W:0]     len_p1;
  logic [LEN_W-1:0]   syms_in;

  function automatic logic [CW-1:0] to_ticks(int unsigned u);
    return CW'(u * TICKS_PER_UNIT);
  endfunction

  assign len_p1  = {1'b0, len_in} + 1'b1;
  assign syms_in = (mode_in == DL_QUAD) ? len_p1[LEN_W:1] : len_in;
  assign cur_sym = (mode_q == DL_QUAD) ? shreg[FRAME_W-1 -: 2] : {1'b0, shreg[FRAME_W-1]};

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = to_ticks(U_GAP);
    case (state_q)
      S_IDLE: begin
        tmr_load = start;
        tmr_val  = to_ticks(U_START);
      end
      S_SGAP: begin
        tmr_load = tmr_expire;
        tmr_val  = (mode_q == DL_LONGREF) ? to_ticks(U_MAX) : to_ticks(sym_units(mode_q, cur_sym));
      end
      S_REF, S_PULSE: begin
        tmr_load = tmr_expire;
        tmr_val  = to_ticks(U_GAP);
      end
      S_GAP: begin
        tmr_load = tmr_expire;
        if (!ref_pend && sym_left == '0) tmr_val = CW'(1);
        else                             tmr_val = to_ticks(sym_units(mode_q, cur_sym));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      mode_q   <= DL_FIXED;
      shreg    <= '0;
      sym_left <= '0;
      ref_pend <= 1'b0;
      field_q  <= 1'b1;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start) begin
          shreg    <= frame_in;
          sym_left <= syms_in;
          mode_q   <= mode_in;
          field_q  <= 1'b0;
          state_q  <= S_SGAP;
        end
        S_SGAP: if (tmr_expire) begin
          field_q <= 1'b1;
          state_q <= (mode_q == DL_LONGREF) ? S_REF : S_PULSE;
        end
        S_REF: if (tmr_expire) begin
          field_q  <= 1'b0;
          ref_pend <= 1'b1;
          state_q  <= S_GAP;
        end
        S_PULSE: if (tmr_expire) begin
          field_q  <= 1'b0;
          sym_left <= sym_left - 1'b1;
          shreg    <= (mode_q == DL_QUAD) ? (shreg << 2) : (shreg << 1);
          state_q  <= S_GAP;
        end
        S_GAP: if (tmr_expire) begin
          field_q <= 1'b1;
          if (ref_pend) begin
            ref_pend <= 1'b0;
            state_q  <= S_PULSE;
          end else if (sym_left == '0) begin
            state_q <= S_FIN;
          end else begin
            state_q <= S_PULSE;
          end
        end
        S_FIN: if (tmr_expire) begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign field_on = field_q;
  assign done     = done_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R10
  idle_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE) |-> field_q);
  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_GAP && start && !tmr_expire) |=> $stable(sym_left) && $stable(shreg));
  // R2
  sym_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PULSE && tmr_expire) |=> (sym_left == $past(sym_left) - 1'b1));

endmodule

// File: rtl/lf_gap_downlink.sv
module lf_gap_downlink
  import lf_dl_pkg::*;
#(
  parameter int          DATA_W         = 32,
  parameter int          ADDR_W         = 3,
  parameter int unsigned TICKS_PER_UNIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_pwd,
  input  logic [6:0]        cmd_ctrl,
  output logic              field_on,
  output logic              done
);
  localparam int FRAME_W = 7 + 2 * DATA_W + ADDR_W;
  localparam int LEN_W   = $clog2(FRAME_W + 1);
  localparam int CW      = $clog2(U_MAX * TICKS_PER_UNIT + 1);

  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len;
  logic               tmr_load, tmr_expire;
  logic [CW-1:0]      tmr_val;

  lf_dl_framer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_framer (
    .data(cmd_data), .addr(cmd_addr), .pwd(cmd_pwd), .ctrl(cmd_ctrl),
    .frame(frame), .len(len)
  );

  lf_dl_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(tmr_load),
    .load_val(tmr_val), .expire(tmr_expire)
  );

  lf_dl_seq #(.FRAME_W(FRAME_W), .LEN_W(LEN_W), .CW(CW), .TICKS_PER_UNIT(TICKS_PER_UNIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_in(frame), .len_in(len),
    .mode_in(dl_mode_e'(cmd_ctrl[4:3])), .tmr_expire(tmr_expire),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .field_on(field_on), .done(done)
  );

endmodule

// File: tb/lf_gap_downlink_bench.sv
module lf_gap_downlink_bench;
  localparam int U = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        start = 1'b0;
  logic [31:0] cmd_data = '0;
  logic [2:0]  cmd_addr = '0;
  logic [31:0] cmd_pwd = '0;
  logic [6:0]  cmd_ctrl = '0;
  logic        field_on, done;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  lf_gap_downlink #(.DATA_W(32), .ADDR_W(3), .TICKS_PER_UNIT(U)) u_lf_gap_downlink (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
    .cmd_data(cmd_data), .cmd_addr(cmd_addr), .cmd_pwd(cmd_pwd), .cmd_ctrl(cmd_ctrl),
    .field_on(field_on), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [31:0] d, input logic [2:0] a, input logic [31:0] p,
                         input logic [6:0] c, input bit inj, input string req);
    bit   eb[0:127];
    int   ep[0:127];
    int   ons[0:255];
    int   offs[0:255];
    int   nb = 0, np = 0, n_on = 0, n_off = 0, run = 0, steps = 0, mm = -1;
    int   m = int'(c[4:3]);
    logic level;
    bit   got_done = 0;
    // expected frame (R3, R4, R5, R8, R9)
    if (m >= 2) eb[nb++] = 0;
    if (m == 3) eb[nb++] = 0;
    if (c[2]) begin eb[nb++] = 0; eb[nb++] = 1; end
    else begin eb[nb++] = 1; eb[nb++] = c[1]; end
    if (c[0]) begin
      if (m >= 2) begin eb[nb++] = 0; eb[nb++] = 0; end
      for (int i = 31; i >= 0; i--) eb[nb++] = p[i];
    end
    eb[nb++] = 0;
    if (!c[6]) for (int i = 31; i >= 0; i--) eb[nb++] = d[i];
    if (!c[5]) for (int i = 2; i >= 0; i--) eb[nb++] = a[i];
    // expected pulse widths (R6, R7, R8, R9)
    if (m == 1) ep[np++] = 154 * U;
    if (m == 3) begin
      for (int i = 0; i < nb; i += 2) begin
        int v = 2 * int'(eb[i]) + ((i + 1 < nb) ? int'(eb[i+1]) : 0);
        ep[np++] = (18 + 16 * v) * U;
      end
    end else begin
      for (int i = 0; i < nb; i++)
        ep[np++] = (eb[i] ? ((m == 2) ? 40 : 50) : 18) * U;
    end

    cmd_data = d; cmd_addr = a; cmd_pwd = p; cmd_ctrl = c;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    level = field_on;
    run = 1;
    check(field_on == 1'b0, "R2", "field off after start", int'(field_on), 0);
    while (!got_done && steps < 20000) begin
      if (inj && steps == 150) begin
        start = 1'b1; cmd_data = ~d; cmd_ctrl = c ^ 7'h18;  // R11 disturbance
      end else start = 1'b0;
      @(negedge clk);
      steps++;
      if (field_on == level) run++;
      else begin
        if (level == 1'b0) offs[n_off++] = run; else ons[n_on++] = run;
        level = field_on;
        run = 1;
      end
      if (done) got_done = 1;
    end
    start = 1'b0;
    check(got_done, "R10", "done seen", int'(got_done), 1);
    check(n_off > 0 && offs[0] == 31 * U, "R2", "start gap width", (n_off > 0) ? offs[0] : -1, 31 * U);
    mm = -1;
    for (int i = n_off - 1; i >= 1; i--) if (offs[i] != 20 * U) mm = i;
    check(mm < 0 && n_off == np + 1, "R2", "gap widths/count", (mm < 0) ? n_off : offs[mm], (mm < 0) ? np + 1 : 20 * U);
    mm = -1;
    for (int i = np - 1; i >= 0; i--) if (i < n_on && ons[i] != ep[i]) mm = i;
    check(mm < 0 && n_on == np, req, "pulse widths", (mm < 0) ? n_on : ons[mm], (mm < 0) ? np : ep[mm]);
    // R10: field high one sample before done, done on the second
    check(level == 1'b1 && run == 2, "R10", "field-high samples up to done", run, 2);
    @(negedge clk);
    check(done == 1'b0 && field_on == 1'b1, "R10", "done single cycle, field stays on",
          int'({done, field_on}), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    string mreq;
    repeat (3) @(negedge clk);
    // R1
    check(field_on == 1'b1, "R1", "field_on in reset", int'(field_on), 1);
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(field_on == 1'b1 && done == 1'b0, "R1", "idle after reset", int'({field_on, done}), 2);
    for (int m = 0; m < 4; m++) begin
      logic [1:0] mb = 2'(m);
      case (m)
        0: mreq = "R6";
        1: mreq = "R7";
        2: mreq = "R8";
        default: mreq = "R9";
      endcase
      // password write, page 0 (R3); first one also disturbs mid-frame (R11)
      run_cmd(32'hA5C3_0F61 ^ (m * 32'h1111), 3'd5, 32'h1234_ABCD, {2'b00, mb, 3'b001}, m == 0, {mreq, "/R3/R11"});
      // plain write, page 1 (R4)
      run_cmd(32'h8000_0001, 3'd2, 32'hFFFF_FFFF, {2'b00, mb, 3'b010}, 1'b0, {mreq, "/R4"});
      // addressed read with password (R5)
      run_cmd(32'hDEAD_BEEF, 3'd7, 32'h0F0F_F0F0, {2'b10, mb, 3'b011}, 1'b0, {mreq, "/R5"});
      // regular read, no password: odd length in pair coding (R5, R9)
      run_cmd(32'h0, 3'd0, 32'h0, {2'b11, mb, 3'b000}, 1'b0, {mreq, "/R5/R9"});
      // test-mode write (R4)
      run_cmd(32'h3C3C_5A5A, 3'd1, 32'h0, {2'b00, mb, 3'b110}, 1'b0, {mreq, "/R4"});
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule